// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU's 16-bit address bus and the memory on a plug-in cartridge. It watches CPU writes to the read-only program area and treats them as control writes. Depending on the address, a write selects which ROM bank appears in the upper 16 kB program window, selects which RAM bank appears in the 8 kB external RAM window, or turns external RAM on or off.

On every cycle, the block turns the current CPU address into an extended ROM address and a banked RAM address without any clock delay. It also drives the ROM chip-select, the RAM chip-select and the RAM write-enable. When the CPU reads the RAM window while RAM is off, the block supplies a fill byte on a separate read-data path. The ROM and RAM arrays themselves are outside the block.

Top module: `cart_bank_ctl`

## Requirements
- R1: After reset, the switchable ROM bank is 1, the RAM bank is 0 and external RAM is off.
- R2: For CPU addresses 0x0000–0x3FFF, and for every address with bit 15 set, the ROM address is {zero bank, cpu_addr[13:0]}, whatever bank is selected.
- R3: A write anywhere in 0x2000–0x3FFF loads the ROM bank from wdata[4:0]. From the next cycle on, addresses 0x4000–0x7FFF map to {bank, cpu_addr[13:0]}.
- R4: A stored ROM bank of 0 is presented as bank 1, so bank 0 never appears in the switchable window.
- R5: A write in 0x4000–0x5FFF loads the RAM bank from wdata[1:0], ignoring the upper bits. The RAM address is {RAM bank, cpu_addr[12:0]}.
- R6: A write of 0x0A in 0x0000–0x1FFF turns external RAM on. A write of any other value there turns it off.
- R7: While RAM is on, a read or write in 0xA000–0xBFFF asserts the RAM chip-select, and a write there also asserts the RAM write-enable.
- R8: While RAM is off, the RAM chip-select and write-enable stay low. A read in 0xA000–0xBFFF then raises the fill strobe, with fill data 0xFF.
- R9: The ROM chip-select is high only for reads in 0x0000–0x7FFF. Writes in 0x6000–0x7FFF change no state.
- R10: Accesses outside 0xA000–0xBFFF never assert the RAM chip-select, the write-enable or the fill strobe, and idle cycles assert nothing.
- R11: Bits 7:5 of a ROM-bank write are ignored, so a value whose low five bits are zero also yields bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| rom_addr | output | 19 | Extended ROM address {bank, offset} |
| rom_cs | output | 1 | ROM chip-select (reads only) |
| ram_addr | output | 15 | Banked RAM address {bank, offset} |
| ram_cs | output | 1 | RAM chip-select |
| ram_we | output | 1 | RAM write-enable |
| fill_oe | output | 1 | Fill data valid (read of RAM while RAM is off) |
| fill_data | output | 8 | Fill byte, 0xFF when fill_oe is high, else 0 |

## Verification
The hardest situation to reach is the interaction of stored state with the address decode. Examples are a RAM bank chosen while RAM is off and then used after RAM is turned on, and a ROM-bank write whose low bits are zero while its high bits are not. The stimulus table walks through an ordered history for this purpose. It loads the bank registers, flips the enable with both the key and a non-key value, and only then probes the windows, so that each probe depends on every earlier write. Directed steps then cover a write followed at once by a read in the next cycle, and a reset that arrives while non-default banks are loaded.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

   localparam int CPU_AW    = 16;
   localparam int ROM_OFS_W = 14;
   localparam int RAM_OFS_W = 13;

   // Which window an address falls in
   typedef enum logic [1:0] {
      RG_FIXED  = 2'd0,
      RG_BANKED = 2'd1,
      RG_XRAM   = 2'd2,
      RG_NONE   = 2'd3
   } cbc_region_e;

   // Which control register a CPU write lands on
   typedef enum logic [1:0] {
      WT_NONE   = 2'd0,
      WT_ENABLE = 2'd1,
      WT_ROMSEL = 2'd2,
      WT_RAMSEL = 2'd3
   } cbc_wtgt_e;

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
   import cbc_pkg::*;
(
   input  logic [2:0]  addr_top,
   input  logic        wr,
   output cbc_region_e region,
   output cbc_wtgt_e   wtgt
);

   cbc_wtgt_e slot;

   always_comb begin
      region = RG_NONE;
      slot   = WT_NONE;
      unique case (addr_top)
         3'b000: begin region = RG_FIXED;  slot = WT_ENABLE; end
         3'b001: begin region = RG_FIXED;  slot = WT_ROMSEL; end
         3'b010: begin region = RG_BANKED; slot = WT_RAMSEL; end
         3'b011: begin region = RG_BANKED; slot = WT_NONE;   end
         3'b101: begin region = RG_XRAM;   slot = WT_NONE;   end
         default: begin region = RG_NONE;  slot = WT_NONE;   end
      endcase
   end

   assign wtgt = wr ? slot : WT_NONE;

endmodule

// File: rtl/cbc_bank_regs.sv
module cbc_bank_regs
   import cbc_pkg::*;
#(
   parameter int         ROM_BANK_W = 5,
   parameter int         RAM_BANK_W = 2,
   parameter logic [7:0] ENABLE_KEY = 8'h0A,
   parameter bit         REMAP_ZERO = 1'b1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  cbc_wtgt_e             wtgt,
   input  logic [7:0]            wdata,
   output logic [ROM_BANK_W-1:0] rom_bank_eff,
   output logic [RAM_BANK_W-1:0] ram_bank,
   output logic                  ram_en
);

   localparam logic [ROM_BANK_W-1:0] ROM_RESET = ROM_BANK_W'(1);

   logic [ROM_BANK_W-1:0] rom_q;
   logic [RAM_BANK_W-1:0] ram_q;
   logic                  en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rom_q <= ROM_RESET;
         ram_q <= '0;
         en_q  <= 1'b0;
      end else begin
         unique case (wtgt)
            WT_ENABLE: en_q  <= (wdata == ENABLE_KEY);
            WT_ROMSEL: rom_q <= wdata[ROM_BANK_W-1:0];
            WT_RAMSEL: ram_q <= wdata[RAM_BANK_W-1:0];
            default:   ;
         endcase
      end
   end

   generate
      if (REMAP_ZERO) begin : g_remap
         assign rom_bank_eff = (rom_q == '0) ? ROM_BANK_W'(1) : rom_q;
         // R4: the presented bank is never zero
         a_r4_no_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rom_bank_eff != '0);
      end else begin : g_direct
         assign rom_bank_eff = rom_q;
      end
   endgenerate

   assign ram_bank = ram_q;
   assign ram_en   = en_q;

   // R6: the key value turns RAM on
   a_r6_key_enables: assert property (@(posedge clk) disable iff (!rst_n)
      (wtgt == WT_ENABLE && wdata == ENABLE_KEY) |=> ram_en);

   // R6: any other value turns RAM off
   a_r6_other_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (wtgt == WT_ENABLE && wdata != ENABLE_KEY) |=> !ram_en);

   // R6: the enable moves only on an enable-range write
   a_r6_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wtgt != WT_ENABLE) |=> $stable(ram_en));

   // R3: a ROM-select write loads the low data bits
   a_r3_rom_sel_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (wtgt == WT_ROMSEL) |=> (rom_q == $past(wdata[ROM_BANK_W-1:0])));

   // R5: a RAM-select write loads the low data bits
   a_r5_ram_sel_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (wtgt == WT_RAMSEL) |=> (ram_bank == $past(wdata[RAM_BANK_W-1:0])));

endmodule

// File: rtl/cbc_map.sv
module cbc_map
   import cbc_pkg::*;
#(
   parameter int         ROM_BANK_W = 5,
   parameter int         RAM_BANK_W = 2,
   parameter logic [7:0] FILL_BYTE  = 8'hFF
)(
   input  logic [ROM_OFS_W-1:0]            offset,
   input  logic                            rd,
   input  logic                            wr,
   input  cbc_region_e                     region,
   input  logic [ROM_BANK_W-1:0]           rom_bank,
   input  logic [RAM_BANK_W-1:0]           ram_bank,
   input  logic                            ram_en,
   output logic [ROM_BANK_W+ROM_OFS_W-1:0] rom_addr,
   output logic                            rom_cs,
   output logic [RAM_BANK_W+RAM_OFS_W-1:0] ram_addr,
   output logic                            ram_cs,
   output logic                            ram_we,
   output logic                            fill_oe,
   output logic [7:0]                      fill_data
);

   logic                  in_rom;
   logic                  in_xram;
   logic [ROM_BANK_W-1:0] bank_sel;

   always_comb begin
      in_rom   = (region == RG_FIXED) || (region == RG_BANKED);
      in_xram  = (region == RG_XRAM);
      bank_sel = (region == RG_BANKED) ? rom_bank : '0;
   end

   assign rom_addr  = {bank_sel, offset};
   assign rom_cs    = rd && !wr && in_rom;
   assign ram_addr  = {ram_bank, offset[RAM_OFS_W-1:0]};
   assign ram_cs    = in_xram && ram_en && (rd || wr);
   assign ram_we    = in_xram && ram_en && wr;
   assign fill_oe   = in_xram && !ram_en && rd && !wr;
   assign fill_data = fill_oe ? FILL_BYTE : 8'h00;

endmodule

// File: rtl/cart_bank_ctl.sv
module cart_bank_ctl
   import cbc_pkg::*;
#(
   parameter int         ROM_BANK_W = 5,
   parameter int         RAM_BANK_W = 2,
   parameter logic [7:0] ENABLE_KEY = 8'h0A,
   parameter logic [7:0] FILL_BYTE  = 8'hFF,
   parameter bit         REMAP_ZERO = 1'b1,
   localparam int        ROM_AW     = ROM_BANK_W + ROM_OFS_W,
   localparam int        RAM_AW     = RAM_BANK_W + RAM_OFS_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [7:0]        cpu_wdata,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              rom_cs,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_cs,
   output logic              ram_we,
   output logic              fill_oe,
   output logic [7:0]        fill_data
);

   generate
      if (ROM_BANK_W < 1 || ROM_BANK_W > 8) begin : g_bad_rom_w
         $error("ROM_BANK_W must lie in 1..8");
      end
      if (RAM_BANK_W < 1 || RAM_BANK_W > 8) begin : g_bad_ram_w
         $error("RAM_BANK_W must lie in 1..8");
      end
      if (CPU_AW != 16) begin : g_bad_aw
         $error("address map assumes a 16-bit CPU bus");
      end
   endgenerate

   cbc_region_e           region;
   cbc_wtgt_e             wtgt;
   logic [ROM_BANK_W-1:0] rom_bank_eff;
   logic [RAM_BANK_W-1:0] ram_bank;
   logic                  ram_en;

   cbc_decode u_decode (
      .addr_top (cpu_addr[15:13]),
      .wr       (cpu_wr),
      .region   (region),
      .wtgt     (wtgt)
   );

   cbc_bank_regs #(
      .ROM_BANK_W (ROM_BANK_W),
      .RAM_BANK_W (RAM_BANK_W),
      .ENABLE_KEY (ENABLE_KEY),
      .REMAP_ZERO (REMAP_ZERO)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wtgt         (wtgt),
      .wdata        (cpu_wdata),
      .rom_bank_eff (rom_bank_eff),
      .ram_bank     (ram_bank),
      .ram_en       (ram_en)
   );

   cbc_map #(
      .ROM_BANK_W (ROM_BANK_W),
      .RAM_BANK_W (RAM_BANK_W),
      .FILL_BYTE  (FILL_BYTE)
   ) u_map (
      .offset    (cpu_addr[ROM_OFS_W-1:0]),
      .rd        (cpu_rd),
      .wr        (cpu_wr),
      .region    (region),
      .rom_bank  (rom_bank_eff),
      .ram_bank  (ram_bank),
      .ram_en    (ram_en),
      .rom_addr  (rom_addr),
      .rom_cs    (rom_cs),
      .ram_addr  (ram_addr),
      .ram_cs    (ram_cs),
      .ram_we    (ram_we),
      .fill_oe   (fill_oe),
      .fill_data (fill_data)
   );

   // R8: RAM strobes stay low while RAM is off
   a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_en |-> (!ram_cs && !ram_we));

   // R7: a RAM write is always inside a RAM select
   a_r7_we_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ram_cs);

   // R9: ROM is never selected during a write
   a_r9_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      rom_cs |-> (cpu_rd && !cpu_wr && !cpu_addr[15]));

   // R10: RAM-side strobes only inside the RAM window
   a_r10_ram_window_only: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_cs || fill_oe) |-> (cpu_addr[15:13] == 3'b101));

   // R2: fixed window always carries a zero bank field
   a_r2_fixed_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:14] != 2'b01) |-> (rom_addr[ROM_AW-1:ROM_OFS_W] == '0));

   // R8: fill strobe and ram select never overlap
   a_r8_fill_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({fill_oe, ram_cs}) <= 1);

endmodule

// File: tb/tb_cart_bank_ctl.sv
`timescale 1ns/1ps
module tb_cart_bank_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [18:0] rom_addr;
   logic        rom_cs;
   logic [14:0] ram_addr;
   logic        ram_cs;
   logic        ram_we;
   logic        fill_oe;
   logic [7:0]  fill_data;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   cart_bank_ctl dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .rom_addr(rom_addr),
      .rom_cs(rom_cs), .ram_addr(ram_addr), .ram_cs(ram_cs),
      .ram_we(ram_we), .fill_oe(fill_oe), .fill_data(fill_data)
   );

   // {req[3:0], op[1:0], addr[15:0], wdata[7:0], rom[18:0], ram[14:0], flags[3:0]}
   // op: 0 idle, 1 write, 2 read. flags: {rom_cs, ram_cs, ram_we, fill_oe}
   localparam int NV = 28;
   localparam logic [67:0] VEC [NV] = '{
      {4'd2,  2'd2, 16'h0123, 8'h00, 19'h00123, 15'h0123, 4'b1000}, // R2
      {4'd1,  2'd2, 16'h4000, 8'h00, 19'h04000, 15'h0000, 4'b1000}, // R1
      {4'd8,  2'd2, 16'hA010, 8'h00, 19'h02010, 15'h0010, 4'b0001}, // R8
      {4'd3,  2'd1, 16'h2100, 8'h05, 19'h02100, 15'h0100, 4'b0000}, // R3
      {4'd3,  2'd2, 16'h7FFF, 8'h00, 19'h17FFF, 15'h1FFF, 4'b1000}, // R3
      {4'd4,  2'd1, 16'h3FFF, 8'h00, 19'h03FFF, 15'h1FFF, 4'b0000}, // R4
      {4'd4,  2'd2, 16'h4ABC, 8'h00, 19'h04ABC, 15'h0ABC, 4'b1000}, // R4
      {4'd3,  2'd1, 16'h2000, 8'hFF, 19'h02000, 15'h0000, 4'b0000}, // R3
      {4'd3,  2'd2, 16'h5555, 8'h00, 19'h7D555, 15'h1555, 4'b1000}, // R3
      {4'd11, 2'd1, 16'h2000, 8'h20, 19'h02000, 15'h0000, 4'b0000}, // R11
      {4'd11, 2'd2, 16'h6000, 8'h00, 19'h06000, 15'h0000, 4'b1000}, // R11
      {4'd5,  2'd1, 16'h4000, 8'h03, 19'h04000, 15'h0000, 4'b0000}, // R5
      {4'd5,  2'd2, 16'hB234, 8'h00, 19'h03234, 15'h7234, 4'b0001}, // R5
      {4'd8,  2'd1, 16'hB234, 8'h55, 19'h03234, 15'h7234, 4'b0000}, // R8
      {4'd6,  2'd1, 16'h0000, 8'h0A, 19'h00000, 15'h6000, 4'b0000}, // R6
      {4'd7,  2'd2, 16'hA001, 8'h00, 19'h02001, 15'h6001, 4'b0100}, // R7
      {4'd7,  2'd1, 16'hBFFF, 8'h11, 19'h03FFF, 15'h7FFF, 4'b0110}, // R7
      {4'd6,  2'd1, 16'h1FFF, 8'h0B, 19'h01FFF, 15'h7FFF, 4'b0000}, // R6
      {4'd6,  2'd2, 16'hA000, 8'h00, 19'h02000, 15'h6000, 4'b0001}, // R6
      {4'd6,  2'd1, 16'h1234, 8'h0A, 19'h01234, 15'h7234, 4'b0000}, // R6
      {4'd5,  2'd1, 16'h5FFF, 8'hFD, 19'h05FFF, 15'h7FFF, 4'b0000}, // R5
      {4'd5,  2'd2, 16'hA100, 8'h00, 19'h02100, 15'h2100, 4'b0100}, // R5
      {4'd10, 2'd2, 16'hC000, 8'h00, 19'h00000, 15'h2000, 4'b0000}, // R10
      {4'd10, 2'd2, 16'h9FFF, 8'h00, 19'h01FFF, 15'h3FFF, 4'b0000}, // R10
      {4'd9,  2'd1, 16'h6000, 8'h77, 19'h06000, 15'h2000, 4'b0000}, // R9
      {4'd9,  2'd2, 16'h4000, 8'h00, 19'h04000, 15'h2000, 4'b1000}, // R9
      {4'd6,  2'd1, 16'h0000, 8'h00, 19'h00000, 15'h2000, 4'b0000}, // R6
      {4'd10, 2'd0, 16'hA000, 8'h00, 19'h02000, 15'h2000, 4'b0000}  // R10
   };

   task automatic drive(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr  = a;
      cpu_wdata = d;
      cpu_wr    = (op == 2'd1);
      cpu_rd    = (op == 2'd2);
      #1;
   endtask

   task automatic compare(input string tag, input logic [18:0] e_rom,
                          input logic [14:0] e_ram, input logic [3:0] e_fl);
      logic [3:0] got_fl;
      logic [7:0] e_fd;
      bit bad = 1'b0;
      got_fl = {rom_cs, ram_cs, ram_we, fill_oe};
      e_fd   = e_fl[0] ? 8'hFF : 8'h00;
      n_vec++;
      if (rom_addr !== e_rom) begin
         bad = 1'b1;
         $display("FAIL %s rom_addr actual %05h expected %05h", tag, rom_addr, e_rom);
      end
      if (ram_addr !== e_ram) begin
         bad = 1'b1;
         $display("FAIL %s ram_addr actual %04h expected %04h", tag, ram_addr, e_ram);
      end
      if (got_fl !== e_fl) begin
         bad = 1'b1;
         $display("FAIL %s strobes actual %04b expected %04b", tag, got_fl, e_fl);
      end
      if (fill_data !== e_fd) begin
         bad = 1'b1;
         $display("FAIL %s fill_data actual %02h expected %02h", tag, fill_data, e_fd);
      end
      if (bad) n_bad++;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state seen while reset is held
      drive(2'd2, 16'h4000, 8'h00);
      repeat (3) @(posedge clk);
      #1;
      compare("R1 reset bank", 19'h04000, 15'h0000, 4'b1000);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [67:0] v;
         string tag;
         v = VEC[i];
         drive(v[63:62], v[61:46], v[45:38]);
         tag = $sformatf("R%0d vec%0d", v[67:64], i);
         compare(tag, v[37:19], v[18:4], v[3:0]);
      end

      // R3: write then immediate read next cycle
      drive(2'd1, 16'h2000, 8'h1E);
      compare("R3 sel write", 19'h02000, 15'h2000, 4'b0000);
      drive(2'd2, 16'h7000, 8'h00);
      compare("R3 back-to-back", 19'h7B000, 15'h3000, 4'b1000);

      // load non-default state, enable RAM, then reset
      drive(2'd1, 16'h4000, 8'h02);
      drive(2'd1, 16'h0000, 8'h0A);
      drive(2'd0, 16'h0000, 8'h00);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: banks and enable back to defaults
      drive(2'd2, 16'h4000, 8'h00);
      compare("R1 rom bank after reset", 19'h04000, 15'h0000, 4'b1000);
      drive(2'd2, 16'hBFFF, 8'h00);
      compare("R1 R8 ram off after reset", 19'h03FFF, 15'h1FFF, 4'b0001);

      drive(2'd0, 16'h0000, 8'h00);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule